// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple synchronous host port and an asynchronous 1M x 16 fast-page-mode DRAM. The host offers one word request at a time: a 20-bit word address, a read or write flag, 16 bits of write data and a two-bit byte mask, with a valid/ready handshake. Read results come back with a one-cycle valid flag. The controller splits the word address into a 10-bit row and a 10-bit column and sends both over the shared 10-bit address bus. It then sequences the row strobe, the two byte-lane column strobes, the write enable and the output enable. It also drives the data pads, with a separate pad-enable output.

Once a row is open it stays open. Further requests to the same row are served with column cycles only. A request to another row, a refresh request or an expired page timer closes the row and waits out the precharge time first. Every DRAM timing is a parameter in clock cycles, rounded up from the nanosecond limits at the chosen clock. Writes use early-write sequencing, so the data bus never turns around during a write.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the row strobe, both column strobes, write enable and output enable are high (inactive), the pad enable is low and the read-valid flag is low.
- R2: The row address is the upper 10 bits of the word address (bits 19:10). It is on the address bus in the cycle the row strobe falls. The column address (bits 9:0) is on the bus in the cycle a column strobe falls.
- R3: Mask bit 1 selects the upper lane (data bits 15:8, upper column strobe) and mask bit 0 selects the lower lane (bits 7:0, lower column strobe). A write lowers only the strobes whose mask bit is 1, so the unselected byte in memory is unchanged. A read lowers both strobes.
- R4: The row strobe stays high for at least T_RP cycles before it falls and stays low for at least T_RAS cycles. A column strobe falls no earlier than T_RCD cycles after the row strobe falls. The column strobes stay low for at least T_CAS cycles and stay high for at least T_CP cycles between two column cycles in one row.
- R5: In a write, write enable is low and the pad enable is high in every cycle a column strobe is low, starting no later than the strobe's falling edge, and output enable stays high. In a read, write enable stays high, the pad enable stays low and output enable is low while the strobes are low.
- R6: The read-valid flag rises for one cycle in the cycle after the column strobes of a read rise. The read data then holds the word stored at the requested address. Results return in request order.
- R7: Consecutive requests to the same open row cause no row-strobe cycle between them; a run of same-row accesses uses a single row-strobe fall.
- R8: A request to a row other than the open one closes the open row, precharges, opens the new row and completes with the correct data.
- R9: The row strobe is never low for more than PAGE_MAX cycles. An open row with no traffic closes by itself before that limit.
- R10: While the refresh request is high, no new request is accepted (ready stays low) and any open row is closed. The acknowledge is high only when the row strobe is high and the precharge time has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in 19:10, column in 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 1 upper byte, bit 0 lower byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| ref_req | input | 1 | Refresh agent asks for the bus |
| ref_ack | output | 1 | Bus free: row closed and precharged |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the pads |
| dram_dq_oe | output | 1 | Pad output enable |
| dram_dq_in | input | 16 | Data from the pads |

## Verification
The hardest case to reach from the ports is the page timer closing a row. It takes a long stretch with the row open and no traffic, and it must never cut a column cycle short. The bench shortens the page limit through the parameter, leaves a row open after an access and watches the row strobe rise on its own within the limit. A refresh request is raised while a row is open and a host request is held pending, which checks that refresh closes the row and blocks new requests.

// File: rtl/fpm_pkg.sv
// fpm_pkg: shared state encoding and lane geometry for the page-mode
// DRAM controller. Assumes a 16-bit device split into two byte lanes.
package fpm_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // row closed, precharge satisfied
        ST_ACT  = 3'd1,  // row strobe low, row address on bus
        ST_COL  = 3'd2,  // column strobes low
        ST_CP   = 3'd3,  // column precharge inside open row
        ST_OPEN = 3'd4,  // row open, waiting for the next decision
        ST_PRE  = 3'd5   // row strobe high, precharge in progress
    } fpm_state_e;
endpackage

// File: rtl/fpm_cnt.sv
// fpm_cnt: phase length counter. Loading N-1 keeps done low for N-1
// cycles, so a state entered with a load lasts N cycles.
// Assumes the load value is never larger than the width allows.
module fpm_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // count down to zero after each load
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpm_page_guard.sv
// fpm_page_guard: measures how long the row strobe has been low.
// ras_ok says the minimum low time is met, expire says no further
// column cycle fits before the maximum low time. age equals the number
// of low cycles minus one.
module fpm_page_guard #(
    parameter int PAGE_MAX = 10000,
    parameter int T_RAS    = 3,
    parameter int STOP     = 9996
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic ras_ok,
    output logic expire
);
    localparam int AW = $clog2(PAGE_MAX + 1);

    logic [AW-1:0] age;

    // age counter, cleared whenever the row strobe is high
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_low)
            age <= '0;
        else
            age <= age + 1'b1;
    end

    assign ras_ok = (age >= AW'(T_RAS - 1));
    assign expire = (age >= AW'(STOP));

    // R9
    page_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low |-> (age < AW'(PAGE_MAX)));
endmodule

// File: rtl/fpm_lanes.sv
// fpm_lanes: per-lane column strobe decode. A read enables every lane;
// a write enables only the lanes whose mask bit is set.
module fpm_lanes #(
    parameter int LANES = 2
) (
    input  logic             active,
    input  logic             wr,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] cas_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // strobe low for the selected lane during a column phase
        assign cas_n[i] = !(active && (!wr || be[i]));
    end
endmodule

// File: rtl/fpm_ctrl.sv
// fpm_ctrl: host-to-DRAM controller for a fast-page-mode part.
// Keeps a row open across same-row requests, closes it on a row miss,
// a refresh request or page-time expiry. All timings are in clock
// cycles and must be at least 1. Writes are early writes.
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int COL_W    = 10,
    parameter int T_RP     = 2,
    parameter int T_RAS    = 3,
    parameter int T_RCD    = 1,
    parameter int T_CAS    = 2,
    parameter int T_CP     = 1,
    parameter int PAGE_MAX = 10000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [LANE_W*LANES-1:0]  req_wdata,
    input  logic [LANES-1:0]         req_be,
    output logic                     rd_valid,
    output logic [LANE_W*LANES-1:0]  rd_data,
    input  logic                     ref_req,
    output logic                     ref_ack,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
    output logic                     dram_ras_n,
    output logic                     dram_ucas_n,
    output logic                     dram_lcas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [LANE_W*LANES-1:0]  dram_dq_out,
    output logic                     dram_dq_oe,
    input  logic [LANE_W*LANES-1:0]  dram_dq_in
);
    localparam int ADDR_W    = ROW_W + COL_W;
    localparam int DQ_W      = LANE_W * LANES;
    localparam int A_W       = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int CNT_W     = $clog2(T_RP + T_RAS + T_RCD + T_CAS + T_CP + 1);
    localparam int PAGE_STOP = PAGE_MAX - T_CAS - T_CP - 1;

    fpm_state_e             state, nxt;
    logic                   ld, cnt_done, ras_ok, expire, accept, hit, row_low;
    logic [CNT_W-1:0]       ldv;
    logic [ROW_W-1:0]       open_row;
    logic [COL_W-1:0]       col_q;
    logic                   wr_q;
    logic [LANES-1:0]       be_q;
    logic [DQ_W-1:0]        wdata_q;
    logic [LANES-1:0]       cas_n_v;
    logic [ROW_W-1:0]       req_row;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign hit     = (req_row == open_row);
    assign row_low = (state != ST_IDLE) && (state != ST_PRE);

    fpm_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ldv),
        .done     (cnt_done)
    );

    fpm_page_guard #(.PAGE_MAX(PAGE_MAX), .T_RAS(T_RAS), .STOP(PAGE_STOP)) u_pg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ras_low (row_low),
        .ras_ok  (ras_ok),
        .expire  (expire)
    );

    fpm_lanes #(.LANES(LANES)) u_ln (
        .active (state == ST_COL),
        .wr     (wr_q),
        .be     (be_q),
        .cas_n  (cas_n_v)
    );

    // next-state decision, phase counter loads and request acceptance
    always_comb begin
        nxt    = state;
        ld     = 1'b0;
        ldv    = '0;
        accept = 1'b0;
        case (state)
            ST_IDLE: if (req_valid && !ref_req) begin
                accept = 1'b1;
                nxt    = ST_ACT;
                ld     = 1'b1;
                ldv    = CNT_W'(T_RCD - 1);
            end
            ST_ACT: if (cnt_done) begin
                nxt = ST_COL;
                ld  = 1'b1;
                ldv = CNT_W'(T_CAS - 1);
            end
            ST_COL: if (cnt_done) begin
                nxt = ST_CP;
                ld  = 1'b1;
                ldv = CNT_W'(T_CP - 1);
            end
            ST_CP: if (cnt_done) nxt = ST_OPEN;
            ST_OPEN: begin
                if (ref_req || expire || (req_valid && !hit)) begin
                    if (ras_ok) begin
                        nxt = ST_PRE;
                        ld  = 1'b1;
                        ldv = CNT_W'(T_RP - 1);
                    end
                end else if (req_valid) begin
                    accept = 1'b1;
                    nxt    = ST_COL;
                    ld     = 1'b1;
                    ldv    = CNT_W'(T_CAS - 1);
                end
            end
            ST_PRE: if (cnt_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // capture the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row <= '0;
            col_q    <= '0;
            wr_q     <= 1'b0;
            be_q     <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            open_row <= req_row;
            col_q    <= req_addr[COL_W-1:0];
            wr_q     <= req_write;
            be_q     <= req_be;
            wdata_q  <= req_wdata;
        end
    end

    // read capture at the last column-strobe cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_COL) && cnt_done && !wr_q;
            if ((state == ST_COL) && cnt_done && !wr_q)
                rd_data <= dram_dq_in;
        end
    end

    assign req_ready   = accept;
    assign ref_ack     = ref_req && (state == ST_IDLE);
    assign dram_ras_n  = !row_low;
    assign dram_ucas_n = cas_n_v[LANES-1];
    assign dram_lcas_n = cas_n_v[0];
    assign dram_we_n   = !((state == ST_COL) && wr_q);
    assign dram_oe_n   = !((state == ST_COL) && !wr_q);
    assign dram_dq_oe  = (state == ST_COL) && wr_q;
    assign dram_dq_out = wdata_q;
    assign dram_a      = (state == ST_ACT) ? A_W'(open_row) : A_W'(col_q);

    // R10
    ack_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (dram_ras_n && !req_ready));

    // R5
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && dram_oe_n));

    // R4
    cas_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (dram_ucas_n && dram_lcas_n));

    // R6
    rd_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!dram_ucas_n && !dram_lcas_n) && dram_ucas_n));

    // R7
    hit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !dram_ras_n) |-> (req_row == open_row));
endmodule

// File: tb/sim_fpm_ctrl.sv
// sim_fpm_ctrl: behavioural DRAM, host shadow memory and strobe timing
// monitor; every clock the pins are compared with the expected protocol.
module sim_fpm_ctrl;
    localparam int P_RP = 2, P_RAS = 3, P_RCD = 1, P_CAS = 2, P_CP = 1, P_MAX = 40;

    typedef struct {
        logic        w;
        logic [9:0]  row;
        logic [9:0]  col;
        logic [1:0]  be;
        logic [15:0] d;
    } req_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rd_valid, ref_ack;
    logic [15:0] rd_data, dq_out, dq_in;
    logic [9:0]  dram_a;
    logic        ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;

    int tests = 0, fails = 0, ras_falls = 0, cycles = 0;
    req_t        pend[$];
    logic [15:0] exp_rd[$];
    logic [15:0] shadow[int];
    logic [15:0] mem[int];

    fpm_ctrl #(.T_RP(P_RP), .T_RAS(P_RAS), .T_RCD(P_RCD), .T_CAS(P_CAS),
               .T_CP(P_CP), .PAGE_MAX(P_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_req(ref_req), .ref_ack(ref_ack), .dram_a(dram_a),
        .dram_ras_n(ras_n), .dram_ucas_n(ucas_n), .dram_lcas_n(lcas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out),
        .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // DRAM model and strobe timing monitor, sampled mid-cycle
    logic p_ras = 1'b1, p_cas = 1'b1, row_used = 1'b0;
    int   lo_len = 0, hi_len = 100, since_fall = 0, cas_lo = 0, cas_hi = 100;
    logic [9:0] m_row = '0;
    always @(negedge clk) begin
        logic cas_now;
        cas_now = ucas_n & lcas_n;
        if (rst_n) begin
            if (!ras_n) begin
                if (p_ras) begin
                    check(hi_len >= P_RP, "R4 precharge", hi_len, P_RP);
                    check(pend.size() > 0 && dram_a == pend[0].row, "R2 row addr",
                          dram_a, pend.size() > 0 ? pend[0].row : 0);
                    m_row = dram_a; lo_len = 1; since_fall = 0; row_used = 1'b0;
                    ras_falls++;
                end else begin
                    lo_len++; since_fall++;
                end
            end else begin
                if (!p_ras) begin
                    check(lo_len >= P_RAS, "R4 ras low min", lo_len, P_RAS);
                    check(lo_len <= P_MAX, "R9 ras low max", lo_len, P_MAX);
                    hi_len = 1;
                end else hi_len++;
            end
            if (!cas_now && p_cas) begin
                check(!ras_n && since_fall >= P_RCD, "R4 ras to cas", since_fall, P_RCD);
                if (row_used) check(cas_hi >= P_CP, "R4 cas precharge", cas_hi, P_CP);
                if (pend.size() == 0) check(1'b0, "R2 unexpected column cycle", 0, 1);
                else begin
                    req_t r;
                    r = pend.pop_front();
                    check(dram_a == r.col && m_row == r.row, "R2 column addr",
                          {m_row, dram_a}, {r.row, r.col});
                    if (r.w) begin
                        check({!ucas_n, !lcas_n} == r.be, "R3 write lanes",
                              {!ucas_n, !lcas_n}, r.be);
                        check(!we_n && dq_oe && oe_n, "R5 early write pins",
                              {we_n, dq_oe, oe_n}, 3'b011);
                        if (!mem.exists({m_row, dram_a})) mem[{m_row, dram_a}] = 16'h0;
                        if (!ucas_n) mem[{m_row, dram_a}][15:8] = dq_out[15:8];
                        if (!lcas_n) mem[{m_row, dram_a}][7:0]  = dq_out[7:0];
                    end else begin
                        check(!ucas_n && !lcas_n, "R3 read lanes", {ucas_n, lcas_n}, 0);
                        check(we_n && !dq_oe && !oe_n, "R5 read pins",
                              {we_n, dq_oe, oe_n}, 3'b100);
                    end
                end
                cas_lo = 1; row_used = 1'b1;
            end else if (!cas_now) cas_lo++;
            else if (!p_cas) begin
                check(cas_lo >= P_CAS, "R4 cas low min", cas_lo, P_CAS);
                cas_hi = 1;
            end else cas_hi++;
            if (rd_valid) begin
                if (exp_rd.size() == 0) check(1'b0, "R6 unexpected read", rd_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_rd.pop_front();
                    check(rd_data == e, "R6 read data", rd_data, e);
                end
            end
        end
        dq_in = (!cas_now && we_n) ?
                (mem.exists({m_row, dram_a}) ? mem[{m_row, dram_a}] : 16'h0) : 16'hBAD0;
        p_ras = ras_n; p_cas = cas_now;
    end

    task automatic do_req(input logic w, input logic [19:0] ad, input logic [15:0] d,
                          input logic [1:0] be);
        logic got;
        req_t r;
        got = 1'b0;
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = w; req_addr = ad; req_wdata = d; req_be = be;
        while (!got) begin
            @(negedge clk);
            if (req_ready) begin
                got = 1'b1;
                r.w = w; r.row = ad[19:10]; r.col = ad[9:0]; r.be = be; r.d = d;
                pend.push_back(r);
                if (!shadow.exists(ad)) shadow[ad] = 16'h0;
                if (w) begin
                    if (be[1]) shadow[ad][15:8] = d[15:8];
                    if (be[0]) shadow[ad][7:0]  = d[7:0];
                end else exp_rd.push_back(shadow[ad]);
            end
        end
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        summary();
    end

    initial begin
        int f0;
        logic bad;
        repeat (4) @(negedge clk);
        // R1 reset state during reset
        check(ras_n && ucas_n && lcas_n && we_n && oe_n && !dq_oe && !rd_valid,
              "R1 reset pins", {ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe, rd_valid}, 7'b1111100);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        check(ras_n && ucas_n && lcas_n && we_n && oe_n && !dq_oe && !rd_valid,
              "R1 after reset", {ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe, rd_valid}, 7'b1111100);

        // R2 R6 full word write and read back
        do_req(1'b1, {10'd5, 10'd3}, 16'h1234, 2'b11);
        do_req(1'b0, {10'd5, 10'd3}, 16'h0, 2'b11);
        // R3 upper lane only, then lower lane only
        do_req(1'b1, {10'd5, 10'd3}, 16'hABCD, 2'b10);
        do_req(1'b0, {10'd5, 10'd3}, 16'h0, 2'b11);
        do_req(1'b1, {10'd5, 10'd3}, 16'h77EF, 2'b01);
        do_req(1'b0, {10'd5, 10'd3}, 16'h0, 2'b11);

        // R7 same-row burst uses one row opening
        f0 = ras_falls;
        for (int i = 0; i < 4; i++) do_req(1'b1, {10'd7, 10'(i)}, 16'(16'h100 + i), 2'b11);
        repeat (3) @(negedge clk);
        check(ras_falls - f0 == 1, "R7 row openings in burst", ras_falls - f0, 1);

        // R8 row miss then back to the old row
        f0 = ras_falls;
        do_req(1'b1, {10'd9, 10'd1}, 16'h5A5A, 2'b11);
        do_req(1'b0, {10'd7, 10'd2}, 16'h0, 2'b11);
        repeat (6) @(negedge clk);
        check(ras_falls - f0 == 2, "R8 row openings on miss", ras_falls - f0, 2);

        // R2 extreme address
        do_req(1'b1, 20'hFFFFF, 16'hC3C3, 2'b11);
        do_req(1'b0, 20'hFFFFF, 16'h0, 2'b11);

        // R9 idle open row closes by itself
        repeat (P_MAX + 10) @(negedge clk);
        check(ras_n == 1'b1, "R9 idle row closed", ras_n, 1);

        // R10 refresh while a row is open and a request waits
        do_req(1'b1, {10'd12, 10'd4}, 16'h4242, 2'b11);
        @(posedge clk); #2; ref_req = 1'b1;
        bad = 1'b1;
        for (int i = 0; i < 20 && bad; i++) begin
            @(negedge clk);
            if (ref_ack) bad = 1'b0;
        end
        check(!bad, "R10 ack seen", bad, 0);
        check(ras_n && hi_len >= P_RP, "R10 bus free at ack", {ras_n, 8'(hi_len)}, 1);
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = 1'b0; req_addr = {10'd12, 10'd4};
        f0 = ras_falls; bad = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (req_ready) bad = 1'b1;
        end
        check(!bad && ras_falls == f0, "R10 requests held off", {bad, 8'(ras_falls - f0)}, 0);
        @(posedge clk); #2; req_valid = 1'b0; ref_req = 1'b0;
        do_req(1'b0, {10'd12, 10'd4}, 16'h0, 2'b11);

        // drain outstanding reads
        for (int i = 0; i < 50 && exp_rd.size() > 0; i++) @(negedge clk);
        check(exp_rd.size() == 0, "R6 all reads returned", exp_rd.size(), 0);
        summary();
    end

    always @(posedge clk) cycles <= cycles + 1;
endmodule